// File: doc/BRIEF.md
# Transmit Frame Assembler with Checksum Insertion

This block builds one outgoing Ethernet frame at a time from a chain of transmit descriptors held in a ring. For each descriptor the host-side logic supplies a 32-bit status word, and the block then pulls that descriptor's segment bytes from a byte stream into a local frame buffer. When a descriptor marks the end of a packet, the block can compute a 16-bit ones'-complement Internet checksum over the frame. The sum runs from a start offset to the end of the frame, and the result is written back into the buffer at a stuff offset. If transmission is enabled, the finished frame then streams out.

The block walks the ring from its current index for as long as descriptors are owned by hardware. Each processed descriptor is returned with its ownership bit cleared. The ring index advances with wraparound. Two sticky status flags are raised, and a pending flag drops once the chain ends. Descriptor and segment fetching is done by the surrounding logic through a simple request/valid exchange, so no bus mastering lives here.

Status word layout, which the surrounding logic must follow: bit 31 hardware-owned, bit 30 first segment of a frame, bit 29 last segment, bit 28 checksum enable, bits 27:20 stuff offset, bits 19:14 checksum start offset, bits 12:0 segment length in bytes.

Top module: `txck_insert`

## Requirements
- R1: After reset, ringIdx is 0, pending, statHostToTx, statTxAll, outValid and wbValid are all 0.
- R2: Every descriptor read with bit 31 set is written back exactly once on wbValid, with its ring index on wbIdx and its status on wbStatus equal to the original word with bit 31 cleared and all other bits unchanged.
- R3: A kick sets pending. The first descriptor read with bit 31 clear ends the chain: it is not written back, statTxAll becomes 1 and pending returns to 0.
- R4: statHostToTx becomes 1 once any descriptor of the chain has been written back, and it stays 0 for a chain that processes none.
- R5: Segment bytes are concatenated in arrival order into a frame that starts at position 0 on a bit-30 descriptor. On a bit-29 descriptor the whole frame is emitted in order, one byte per cycle on outValid/outData, with outLast on the final byte.
- R6: With txEnable at 0 no byte is emitted, while descriptors are still consumed and written back.
- R7: When the last descriptor has bit 28 set, the block computes a 16-bit value over frame bytes from the start offset to the frame end. Bytes at even absolute positions are the high half of a big-endian word, an odd trailing byte is padded with zero, carries are folded in, and the result is inverted. The high byte goes to the stuff offset and the low byte to the stuff offset plus 1.
- R8: The checksum start offset may fall inside any segment. Bytes before it are excluded, and bytes of later segments are all included, each segment's bytes counting only when that segment's bit 28 is set.
- R9: With bit 28 clear on the last descriptor, the emitted frame equals the received bytes, whatever the offset fields hold.
- R10: The frame buffer holds 2048 bytes. A segment that would pass the end is cut to the remaining room, and only that many bytes are taken from the byte stream.
- R11: The ring has (ringSize + 1) × 16 entries. After the last entry the index returns to 0.
- R12: A bit-30 descriptor discards the previous frame's position and running sum, so each frame's checksum and contents depend only on its own segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start walking the ring (accepted when idle) |
| txEnable | input | 1 | Transmit enable; frames are emitted only when 1 |
| ringSize | input | 4 | Ring size code; entries = (ringSize+1)*16 |
| descReq | output | 1 | Requests the status word of entry ringIdx |
| ringIdx | output | 8 | Current ring index |
| descValid | input | 1 | descStatus is valid for the requested entry |
| descStatus | input | 32 | Descriptor status word |
| byteReady | output | 1 | Block takes a segment byte this cycle if byteValid |
| byteValid | input | 1 | Segment byte present |
| byteData | input | 8 | Segment byte |
| outValid | output | 1 | Emitted frame byte valid |
| outData | output | 8 | Emitted frame byte |
| outLast | output | 1 | Final byte of the emitted frame |
| wbValid | output | 1 | Descriptor write-back strobe |
| wbIdx | output | 8 | Ring index of the written-back descriptor |
| wbStatus | output | 32 | Status word with ownership cleared |
| pending | output | 1 | A chain is being processed |
| statHostToTx | output | 1 | At least one descriptor processed since the kick |
| statTxAll | output | 1 | Chain finished |

## Verification
The assertions take several things as given about the surroundings. txEnable and ringSize hold steady while pending is 1. The descriptor answering a request is the one for ringIdx. The stuff offset plus one lies inside the buffer. Only under those conditions do the checks that emission happens only while enabled and that the index stays below the ring count mean anything. The stimulus changes txEnable and ringSize only between chains, with the block idle. It serves status words straight from a table indexed by the requested ringIdx. It places checksum fields so that the stuffed pair lands inside the frame, and it runs some segments with gaps in byteValid so that the byte count is exercised under stalls.

// File: rtl/txck_pkg.sv
`timescale 1ns/1ps
package txck_pkg;
  localparam int OWN_BIT   = 31;
  localparam int SOP_BIT   = 30;
  localparam int EOP_BIT   = 29;
  localparam int CKS_BIT   = 28;
  localparam int STUFF_LSB = 20;
  localparam int STUFF_W   = 8;
  localparam int START_LSB = 14;
  localparam int START_W   = 6;
  localparam int LEN_W     = 13;

  // strobes from control to datapath
  typedef struct packed {
    logic frameClr;  // new frame: clear position/sum, latch offsets
    logic byteWr;    // store incoming byte
    logic sumEn;     // include stored byte in the sum when past start
    logic stuffHi;   // write checksum high byte
    logic stuffLo;   // write checksum low byte
    logic emitRd;    // read one byte toward the output
  } dpCmd_t;
endpackage

// File: rtl/txck_data.sv
`timescale 1ns/1ps
module txck_data
  import txck_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int POS_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCmd_t           cmd,
  input  logic [31:0]      descStatus,
  input  logic [7:0]       byteData,
  output logic [POS_W-1:0] framePos,
  output logic             emitLast,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outLast
);
  localparam int ADDR_W = $clog2(BUF_BYTES);
  localparam int ACC_W  = POS_W + 16;

  logic [7:0]         frameBuf [BUF_BYTES];
  logic [POS_W-1:0]   pos;
  logic [POS_W-1:0]   rdPtr;
  logic [ACC_W-1:0]   acc;
  logic [START_W-1:0] csStart;
  logic [STUFF_W-1:0] csStuff;
  logic [16:0]        fold1;
  logic [16:0]        fold2;
  logic [15:0]        ckValue;
  logic               inRange;
  logic [ACC_W-1:0]   addTerm;

  assign framePos = pos;
  assign emitLast = (rdPtr == pos - POS_W'(1));
  assign inRange  = (pos >= POS_W'(csStart));
  assign addTerm  = pos[0] ? ACC_W'(byteData) : (ACC_W'(byteData) << 8);

  // two folds suffice for ACC_W bits of byte-wise accumulation
  always_comb begin
    fold1   = 17'(acc[15:0]) + 17'(acc[ACC_W-1:16]);
    fold2   = 17'(fold1[15:0]) + 17'(fold1[16]);
    ckValue = ~fold2[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      acc     <= '0;
      csStart <= '0;
      csStuff <= '0;
      rdPtr   <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      if (cmd.frameClr) begin
        pos     <= '0;
        acc     <= '0;
        csStart <= descStatus[START_LSB +: START_W];
        csStuff <= descStatus[STUFF_LSB +: STUFF_W];
      end else if (cmd.byteWr) begin
        pos <= pos + POS_W'(1);
        if (cmd.sumEn && inRange) acc <= acc + addTerm;
      end
      rdPtr    <= cmd.emitRd ? rdPtr + POS_W'(1) : '0;
      outValid <= cmd.emitRd;
      outLast  <= cmd.emitRd && emitLast;
    end
  end

  // buffer storage and read port, no reset
  always_ff @(posedge clk) begin
    if (cmd.byteWr)
      frameBuf[pos[ADDR_W-1:0]] <= byteData;
    else if (cmd.stuffHi)
      frameBuf[ADDR_W'(csStuff)] <= ckValue[15:8];
    else if (cmd.stuffLo)
      frameBuf[ADDR_W'(csStuff) + ADDR_W'(1)] <= ckValue[7:0];
    outData <= frameBuf[rdPtr[ADDR_W-1:0]];
  end

  // R10
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(BUF_BYTES))
    else $error("frame position beyond buffer");

  // R10
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.byteWr |-> pos < POS_W'(BUF_BYTES))
    else $error("byte stored into a full buffer");

  // R5
  emit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outLast) |=> outValid)
    else $error("emitted frame interrupted before its last byte");
endmodule

// File: rtl/txck_ctrl.sv
`timescale 1ns/1ps
module txck_ctrl
  import txck_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int IDX_W     = 8,
  parameter int RSZ_W     = 4,
  parameter int POS_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             txEnable,
  input  logic [RSZ_W-1:0] ringSize,
  input  logic             descValid,
  input  logic [31:0]      descStatus,
  input  logic             byteValid,
  input  logic [POS_W-1:0] framePos,
  input  logic             emitLast,
  output logic             descReq,
  output logic [IDX_W-1:0] ringIdx,
  output logic             byteReady,
  output dpCmd_t           cmd,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [31:0]      wbStatus,
  output logic             pending,
  output logic             statHostToTx,
  output logic             statTxAll
);
  localparam int CNT_W = RSZ_W + 5;
  localparam int CMP_W = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DATA, S_POST, S_STUFF_HI, S_STUFF_LO, S_EMIT, S_WB
  } state_t;

  state_t           state;
  logic [31:0]      curStatus;
  logic [POS_W-1:0] remain;
  logic [CNT_W-1:0] ringCount;
  logic [CNT_W-1:0] idxPlus;
  logic [IDX_W-1:0] nextIdx;
  logic             descOwned;
  logic             descSop;
  logic [POS_W-1:0] effPos;
  logic [CMP_W-1:0] segLen;
  logic [CMP_W-1:0] room;
  logic [CMP_W-1:0] takeLen;
  logic             canEmit;

  assign ringCount = CNT_W'({1'b0, ringSize} + 1) << 4;
  assign idxPlus   = CNT_W'(ringIdx) + CNT_W'(1);
  assign nextIdx   = (idxPlus >= ringCount) ? '0 : IDX_W'(idxPlus);

  assign descOwned = descStatus[OWN_BIT];
  assign descSop   = descStatus[SOP_BIT];
  assign effPos    = descSop ? '0 : framePos;
  assign segLen    = CMP_W'(descStatus[LEN_W-1:0]);
  assign room      = CMP_W'(BUF_BYTES) - CMP_W'(effPos);
  assign takeLen   = (segLen > room) ? room : segLen;
  assign canEmit   = txEnable && (framePos != '0);

  assign descReq   = (state == S_FETCH);
  assign byteReady = (state == S_DATA);

  always_comb begin
    cmd          = '0;
    cmd.frameClr = (state == S_FETCH) && descValid && descOwned && descSop;
    cmd.byteWr   = (state == S_DATA) && byteValid;
    cmd.sumEn    = curStatus[CKS_BIT];
    cmd.stuffHi  = (state == S_STUFF_HI);
    cmd.stuffLo  = (state == S_STUFF_LO);
    cmd.emitRd   = (state == S_EMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      curStatus    <= '0;
      remain       <= '0;
      ringIdx      <= '0;
      wbValid      <= 1'b0;
      wbIdx        <= '0;
      wbStatus     <= '0;
      pending      <= 1'b0;
      statHostToTx <= 1'b0;
      statTxAll    <= 1'b0;
    end else begin
      wbValid <= 1'b0;
      unique case (state)
        S_IDLE: if (kick) begin
          pending      <= 1'b1;
          statHostToTx <= 1'b0;
          statTxAll    <= 1'b0;
          state        <= S_FETCH;
        end
        S_FETCH: if (descValid) begin
          if (!descOwned) begin
            pending   <= 1'b0;
            statTxAll <= 1'b1;
            state     <= S_IDLE;
          end else begin
            curStatus <= descStatus;
            remain    <= POS_W'(takeLen);
            state     <= (takeLen == '0) ? S_POST : S_DATA;
          end
        end
        S_DATA: if (byteValid) begin
          remain <= remain - POS_W'(1);
          if (remain == POS_W'(1)) state <= S_POST;
        end
        S_POST: begin
          if (!curStatus[EOP_BIT])      state <= S_WB;
          else if (curStatus[CKS_BIT])  state <= S_STUFF_HI;
          else if (canEmit)             state <= S_EMIT;
          else                          state <= S_WB;
        end
        S_STUFF_HI: state <= S_STUFF_LO;
        S_STUFF_LO: state <= canEmit ? S_EMIT : S_WB;
        S_EMIT: if (emitLast) state <= S_WB;
        S_WB: begin
          wbValid      <= 1'b1;
          wbIdx        <= ringIdx;
          wbStatus     <= curStatus & ~(32'(1) << OWN_BIT);
          ringIdx      <= nextIdx;
          statHostToTx <= 1'b1;
          state        <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> !wbStatus[OWN_BIT])
    else $error("write-back still owned by hardware");

  // R3
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> statTxAll)
    else $error("pending dropped without transmit-all");

  // R4
  host_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> statHostToTx)
    else $error("write-back without host-to-transmit flag");

  // R6
  emit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.emitRd |-> txEnable)
    else $error("emission while transmit disabled");

  // R11
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (CNT_W'(ringIdx) < ringCount))
    else $error("ring index beyond ring count");

  // R5
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(descReq && byteReady))
    else $error("descriptor and byte requested together");
endmodule

// File: rtl/txck_insert.sv
`timescale 1ns/1ps
module txck_insert
  import txck_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int IDX_W     = 8,
  parameter int RSZ_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             txEnable,
  input  logic [RSZ_W-1:0] ringSize,
  output logic             descReq,
  output logic [IDX_W-1:0] ringIdx,
  input  logic             descValid,
  input  logic [31:0]      descStatus,
  output logic             byteReady,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outLast,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [31:0]      wbStatus,
  output logic             pending,
  output logic             statHostToTx,
  output logic             statTxAll
);
  localparam int POS_W = $clog2(BUF_BYTES + 1);

  dpCmd_t           cmd;
  logic [POS_W-1:0] framePos;
  logic             emitLast;

  txck_ctrl #(
    .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .RSZ_W(RSZ_W), .POS_W(POS_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .kick(kick), .txEnable(txEnable),
    .ringSize(ringSize), .descValid(descValid), .descStatus(descStatus),
    .byteValid(byteValid), .framePos(framePos), .emitLast(emitLast),
    .descReq(descReq), .ringIdx(ringIdx), .byteReady(byteReady), .cmd(cmd),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbStatus(wbStatus),
    .pending(pending), .statHostToTx(statHostToTx), .statTxAll(statTxAll)
  );

  txck_data #(
    .BUF_BYTES(BUF_BYTES), .POS_W(POS_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .descStatus(descStatus),
    .byteData(byteData), .framePos(framePos), .emitLast(emitLast),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );
endmodule

// File: tb/test_txck_insert.sv
`timescale 1ns/1ps
module test_txck_insert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic        txEnable = 1'b1;
  logic [3:0]  ringSize = 4'd0;
  logic        descReq;
  logic [7:0]  ringIdx;
  logic        descValid = 1'b0;
  logic [31:0] descStatus = '0;
  logic        byteReady;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        outValid;
  logic [7:0]  outData;
  logic        outLast;
  logic        wbValid;
  logic [7:0]  wbIdx;
  logic [31:0] wbStatus;
  logic        pending;
  logic        statHostToTx;
  logic        statTxAll;

  txck_insert i_txck_insert (.*);

  always #2 clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  logic [31:0] descTab [256];
  logic [7:0]  fb [2048];
  logic [7:0]  expOut [4096];
  logic        expLst [4096];
  logic [7:0]  obsOut [4096];
  logic        obsLst [4096];
  int          expAcc [256];
  int          obsAcc [256];
  int          expWbIdx [64];
  logic [31:0] expWbSt [64];
  int          obsWbIdx [64];
  logic [31:0] obsWbSt [64];
  int expN, obsN, expWbN, obsWbN, expEndIdx;
  bit stallMode = 0;
  int cur = 0, k = 0;
  bit xfer = 0;

  function automatic logic [7:0] segByte(int d, int kk);
    return 8'((d * 37 + kk * 13 + 5) & 255);
  endfunction

  function automatic logic [31:0] mkSt(bit own, bit sop, bit eop, bit cks,
                                       int stuff, int start, int len);
    return {own, sop, eop, cks, 8'(stuff), 6'(start), 1'b0, 13'(len)};
  endfunction

  function automatic int ringCnt();
    return (int'(ringSize) + 1) * 16;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nChecks++; nFail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        summary();
        $finish;
      end
    end
  end

  // descriptor / byte responder and output observer
  always @(negedge clk) begin
    if (xfer) begin k++; obsAcc[cur]++; end
    descValid  = descReq;
    descStatus = descTab[ringIdx];
    if (descReq) begin cur = int'(ringIdx); k = 0; end
    byteValid = stallMode ? ((cyc % 3) != 0) : 1'b1;
    byteData  = segByte(cur, k);
    xfer = byteReady && byteValid;
    if (outValid) begin
      obsOut[obsN] = outData; obsLst[obsN] = outLast; obsN++;
    end
    if (wbValid) begin
      obsWbIdx[obsWbN] = int'(wbIdx); obsWbSt[obsWbN] = wbStatus; obsWbN++;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // expected behaviour computed from the requirements
  task automatic model(int startIdx, bit en);
    int idx = startIdx, pos = 0, cst = 0, csf = 0, sum = 0, take;
    logic [31:0] st;
    expN = 0; expWbN = 0;
    for (int i = 0; i < 256; i++) expAcc[i] = 0;
    while (descTab[idx][31]) begin
      st = descTab[idx];
      if (st[30]) begin pos = 0; sum = 0; cst = int'(st[19:14]); csf = int'(st[27:20]); end
      take = int'(st[12:0]);
      if (take > 2048 - pos) take = 2048 - pos;
      expAcc[idx] = take;
      for (int j = 0; j < take; j++) begin
        fb[pos] = segByte(idx, j);
        if (st[28] && pos >= cst) sum += (pos % 2 == 0) ? int'(fb[pos]) * 256 : int'(fb[pos]);
        pos++;
      end
      expWbIdx[expWbN] = idx; expWbSt[expWbN] = st & 32'h7fff_ffff; expWbN++;
      if (st[29]) begin
        if (st[28]) begin
          while (sum > 16'hffff) sum = (sum & 16'hffff) + (sum >>> 16);
          sum = (~sum) & 16'hffff;
          fb[csf] = 8'(sum >>> 8); fb[csf + 1] = 8'(sum);
        end
        if (en && pos > 0)
          for (int j = 0; j < pos; j++) begin
            expOut[expN] = fb[j]; expLst[expN] = (j == pos - 1); expN++;
          end
      end
      idx = (idx + 1 >= ringCnt()) ? 0 : idx + 1;
    end
    expEndIdx = idx;
  endtask

  task automatic runChain(string dataReq, bit en);
    int bad = -1, badWb = -1, badAcc = -1, t = 0;
    txEnable = en;
    model(int'(ringIdx), en);
    obsN = 0; obsWbN = 0;
    for (int i = 0; i < 256; i++) obsAcc[i] = 0;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    chk(pending == 1'b1, "R3", "pending after kick", pending, 1);
    while (pending && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(obsN == expN, dataReq, "emitted byte count", obsN, expN);
    for (int i = 0; i < expN && i < obsN; i++)
      if (bad < 0 && (obsOut[i] != expOut[i] || obsLst[i] != expLst[i])) bad = i;
    chk(bad < 0, dataReq, "frame byte/last mismatch",
        bad < 0 ? 0 : obsOut[bad], bad < 0 ? 0 : expOut[bad]);
    chk(obsWbN == expWbN, "R2", "write-back count", obsWbN, expWbN);
    for (int i = 0; i < expWbN && i < obsWbN; i++)
      if (badWb < 0 && (obsWbIdx[i] != expWbIdx[i] || obsWbSt[i] != expWbSt[i])) badWb = i;
    chk(badWb < 0, "R2", "write-back status",
        badWb < 0 ? 0 : obsWbSt[badWb], badWb < 0 ? 0 : expWbSt[badWb]);
    chk(int'(ringIdx) == expEndIdx, "R11", "ring index after chain", ringIdx, expEndIdx);
    chk(statTxAll && !pending, "R3", "chain end flags", {statTxAll, pending}, 2'b10);
    chk(statHostToTx == (expWbN > 0), "R4", "host-to-transmit flag", statHostToTx, expWbN > 0);
    for (int i = 0; i < 256; i++) if (badAcc < 0 && obsAcc[i] != expAcc[i]) badAcc = i;
    chk(badAcc < 0, "R10", "bytes taken per segment",
        badAcc < 0 ? 0 : obsAcc[badAcc], badAcc < 0 ? 0 : expAcc[badAcc]);
  endtask

  // place descriptors from the current index, then a terminator
  int putIdx;
  task automatic put(logic [31:0] st);
    descTab[putIdx] = st;
    putIdx = (putIdx + 1 >= ringCnt()) ? 0 : putIdx + 1;
  endtask
  task automatic endChain();
    descTab[putIdx] = 32'h0;
  endtask

  task automatic testReset();
    chk(ringIdx == 0, "R1", "ringIdx at reset", ringIdx, 0);
    chk(!pending && !statHostToTx && !statTxAll, "R1", "flags at reset",
        {pending, statHostToTx, statTxAll}, 0);
    chk(!outValid && !wbValid, "R1", "strobes at reset", {outValid, wbValid}, 0);
  endtask

  task automatic testSingle();   // R5 R2 R4
    putIdx = int'(ringIdx);
    put(mkSt(1, 1, 1, 0, 0, 0, 20)); endChain();
    runChain("R5", 1);
  endtask

  task automatic testMidStart(); // R7 R8, start inside second segment
    stallMode = 1;
    putIdx = int'(ringIdx);
    put(mkSt(1, 1, 0, 1, 30, 14, 10));
    put(mkSt(1, 0, 0, 1, 0, 0, 7));
    put(mkSt(1, 0, 1, 1, 0, 0, 20)); endChain();
    runChain("R8", 1);
    stallMode = 0;
  endtask

  task automatic testOddStart(); // R7 odd start, odd length, stuff before start
    putIdx = int'(ringIdx);
    put(mkSt(1, 1, 1, 1, 2, 13, 41)); endChain();
    runChain("R7", 1);
  endtask

  task automatic testDisabled(); // R6
    putIdx = int'(ringIdx);
    put(mkSt(1, 1, 0, 1, 4, 3, 12));
    put(mkSt(1, 0, 1, 1, 0, 0, 9)); endChain();
    runChain("R6", 0);
  endtask

  task automatic testTwoFrames(); // R9 first frame, R12 second frame
    putIdx = int'(ringIdx);
    put(mkSt(1, 1, 1, 0, 5, 7, 33));
    put(mkSt(1, 1, 0, 1, 6, 1, 5));
    put(mkSt(1, 0, 1, 1, 0, 0, 16)); endChain();
    runChain("R12", 1);
    putIdx = int'(ringIdx);
    put(mkSt(1, 1, 1, 0, 10, 11, 24)); endChain();
    runChain("R9", 1);
  endtask

  task automatic testTruncate(); // R10
    putIdx = int'(ringIdx);
    put(mkSt(1, 1, 0, 1, 40, 20, 2000));
    put(mkSt(1, 0, 1, 1, 0, 0, 100)); endChain();
    runChain("R10", 1);
  endtask

  task automatic testEmpty();   // R3 R4: nothing owned
    descTab[ringIdx] = 32'h0;
    runChain("R3", 1);
  endtask

  task automatic testWrap();    // R11
    int n;
    if (ringIdx < 3) begin
      putIdx = int'(ringIdx);
      for (int i = 0; i < 4; i++) put(mkSt(1, 1, 1, 0, 0, 0, 3));
      endChain();
      runChain("R5", 1);
    end
    n = 16 - int'(ringIdx) + 2;
    putIdx = int'(ringIdx);
    for (int i = 0; i < n; i++) put(mkSt(1, 1, 1, (i % 2 == 1), 0, 0, 4 + i));
    endChain();
    runChain("R11", 1);
    chk(ringIdx == 2, "R11", "index wrapped past last entry", ringIdx, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) descTab[i] = 32'h0;
    obsN = 0; obsWbN = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testMidStart();
    testOddStart();
    testDisabled();
    testTwoFrames();
    testTruncate();
    testEmpty();
    testWrap();
    summary();
    $finish;
  end
endmodule